// File: doc/BRIEF.md
# Serial Audio Word Receiver

This block is the receive side of a synchronous serial link. Words arrive one bit per bit-clock period, most significant bit first. A frame-sync level that is high during the first bit marks the start of each word. The shifter samples every bit on the rising edge of the bit clock. A finished word is handed to a small holding store. A read strobe on a simple register port takes words out of that store, oldest first.

A direction input picks where the bit clock and frame sync come from. They are either taken from pins and brought into the system clock domain, or made by an internal divider and driven out on the clock and frame-sync outputs. The receive enable decides whether a word in flight is kept, and it is judged only at the word's last two bits. The buffer enable picks the fill level at which the full flag rises: one word, or the whole store. A sticky overrun flag records any word that arrived with nowhere to go.

Top module: `serial_rx`

## Requirements
- R1: Words are assembled most significant bit first. The bit sampled while frame sync is high is the first bit of a new word. `rd_data` shows the oldest stored word, or zero when the store is empty.
- R2: In external mode, `ext_sck`, `ext_fs` and `sdi` each pass through a two-flop synchronizer. A completed word appears at the read port on the fourth rising system clock edge after the last bit's rising bit-clock edge at the pin, and not before.
- R3: If `rx_en` is low at the sample of the second-to-last bit or of the last bit, the word is discarded and the store does not change.
- R4: A word is kept when `rx_en` is high at the samples of both of its last two bits, even if `rx_en` was low for earlier bits.
- R5: With `buf_en` low, the store holds one word and `rx_full` rises as soon as one word is held.
- R6: With `buf_en` high, the store holds up to BUF_DEPTH (2) words, and `rx_full` rises only when that many are held.
- R7: A cycle with `rd_en` high removes the oldest word. `rx_full` falls once fewer words than the current capacity remain.
- R8: A word that completes when the store is at its capacity is dropped and sets `overrun`. The flag stays set until a cycle with `rd_en` high clears it.
- R9: `rx_irq` is high exactly when `rx_full` and `int_en` are both high.
- R10: With `dir_int` high, `clk_oe` is high and the block drives its own bit clock on `sck_out`, with a period of 2*HALF_DIV system clocks. `fs_out` is high for the first bit of every frame of SLOT_BITS bits, and a word sent on these clocks is received. With `dir_int` low, `clk_oe` is low.
- R11: When a read and a word completion fall in the same cycle, the read is taken first. A word completing into a full store that is read in that same cycle is stored, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, judged at the last two bits of a word |
| buf_en | input | 1 | Selects full-depth store (1) or single word (0) |
| int_en | input | 1 | Interrupt enable |
| dir_int | input | 1 | 1: internal bit clock and frame sync, 0: taken from pins |
| ext_sck | input | 1 | External bit clock |
| ext_fs | input | 1 | External frame sync, high during the first bit |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Internally generated bit clock |
| fs_out | output | 1 | Internally generated frame sync |
| clk_oe | output | 1 | Output enable for `sck_out` and `fs_out` |
| rd_en | input | 1 | Read strobe, pops the oldest word |
| rd_data | output | WORD_BITS | Oldest stored word, zero when empty |
| rx_full | output | 1 | Store has reached its current capacity |
| rx_irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky flag for a dropped word |

## Verification
A word completion and a read strobe can meet in the same cycle. That is the case where a wrong order inside the store would either lose a word or flag an overrun by mistake. The bench watches its own model for the cycle in which a finished word is about to be stored, and places the read strobe exactly on that edge while the store already holds one word in single-word mode. It then expects the new word at the read port, the full flag still high and no overrun. A reference model fed only by the pin activity is compared with the flags and the read data on every cycle, so any skew in that ordering also shows up as a cycle-level mismatch.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   // one sample of the three serial lines, kept together through the synchronizer
   typedef struct packed {
      logic sck;
      logic fs;
      logic sd;
   } rx_line_t;

   localparam int unsigned LINE_W = $bits(rx_line_t);

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serial_rx_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("serial_rx_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_bitgen.sv
module serial_rx_bitgen #(
   parameter int unsigned HALF_DIV  = 4,
   parameter int unsigned SLOT_BITS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck_o,
   output logic fs_o,
   output logic tick_o
);

   localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int unsigned POS_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
   localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF_DIV - 1);
   localparam logic [POS_W-1:0] SLOT_END = POS_W'(SLOT_BITS - 1);

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("serial_rx_bitgen: HALF_DIV must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [POS_W-1:0] slot_pos;
   logic [POS_W-1:0] slot_nxt;

   assign slot_nxt = (slot_pos == SLOT_END) ? '0 : slot_pos + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         sck_o    <= 1'b0;
         fs_o     <= 1'b1;
         slot_pos <= '0;
         tick_o   <= 1'b0;
      end else if (!run) begin
         div_q    <= '0;
         sck_o    <= 1'b0;
         fs_o     <= 1'b1;
         slot_pos <= '0;
         tick_o   <= 1'b0;
      end else begin
         tick_o <= 1'b0;
         if (div_q == DIV_END) begin
            div_q <= '0;
            sck_o <= ~sck_o;
            if (!sck_o) begin
               // rising edge of the bit clock: sample point
               tick_o <= 1'b1;
            end else begin
               // falling edge: step to the next bit of the frame
               slot_pos <= slot_nxt;
               fs_o     <= (slot_nxt == '0);
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/serial_rx_shift.sv
module serial_rx_shift #(
   parameter int unsigned WORD_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 fs,
   input  logic                 sd,
   input  logic                 rx_en,
   output logic                 done_o,
   output logic [WORD_BITS-1:0] word_o
);

   localparam int unsigned POS_W = $clog2(WORD_BITS + 1);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_BITS - 1);
   localparam logic [POS_W-1:0] PEN_POS  = POS_W'(WORD_BITS - 2);

   generate
      if (WORD_BITS < 3) begin : g_bad_word
         $error("serial_rx_shift: WORD_BITS must be at least 3");
      end
   endgenerate

   logic [WORD_BITS-1:0] sreg;
   logic [POS_W-1:0]     next_pos;
   logic [POS_W-1:0]     pos;
   logic                 busy;
   logic                 en_hold;
   logic                 take;

   always_comb begin
      pos  = fs ? '0 : next_pos;
      take = tick && (fs || busy);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg     <= '0;
         next_pos <= '0;
         busy     <= 1'b0;
         en_hold  <= 1'b0;
         done_o   <= 1'b0;
         word_o   <= '0;
      end else begin
         done_o <= 1'b0;
         if (take) begin
            sreg     <= {sreg[WORD_BITS-2:0], sd};
            next_pos <= pos + 1'b1;
            busy     <= (pos != LAST_POS);
            if (pos == PEN_POS) en_hold <= rx_en;
            if (pos == LAST_POS) begin
               done_o <= en_hold && rx_en;
               word_o <= {sreg[WORD_BITS-2:0], sd};
            end
         end
      end
   end

endmodule

// File: rtl/serial_rx_buf.sv
module serial_rx_buf #(
   parameter int unsigned WORD_BITS = 8,
   parameter int unsigned DEPTH     = 2,
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [WORD_BITS-1:0] wdata,
   input  logic                 rd,
   input  logic                 buf_en,
   output logic [WORD_BITS-1:0] rdata,
   output logic [CNT_W-1:0]     fill_o,
   output logic [CNT_W-1:0]     cap_o,
   output logic                 full_o,
   output logic                 ovr_o
);

   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("serial_rx_buf: DEPTH must be at least 2");
      end
   endgenerate

   logic [WORD_BITS-1:0] mem [DEPTH];
   logic [PTR_W-1:0]     wptr;
   logic [PTR_W-1:0]     rptr;
   logic [CNT_W-1:0]     fill;
   logic [CNT_W-1:0]     after_pop;
   logic                 pop;
   logic                 push;

   always_comb begin
      cap_o     = buf_en ? CNT_W'(DEPTH) : CNT_W'(1);
      pop       = rd && (fill != '0);
      after_pop = fill - CNT_W'(pop);
      push      = wr && (after_pop < cap_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         fill  <= '0;
         ovr_o <= 1'b0;
      end else begin
         if (pop)  rptr <= (rptr == PTR_END) ? '0 : rptr + 1'b1;
         if (push) wptr <= (wptr == PTR_END) ? '0 : wptr + 1'b1;
         fill <= after_pop + CNT_W'(push);
         if (wr && !push) ovr_o <= 1'b1;
         else if (rd)     ovr_o <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wdata;
   end

   assign rdata  = (fill != '0) ? mem[rptr] : '0;
   assign fill_o = fill;
   assign full_o = (fill >= cap_o);

endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
   parameter int unsigned WORD_BITS   = 8,
   parameter int unsigned BUF_DEPTH   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HALF_DIV    = 4,
   parameter int unsigned SLOT_BITS   = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_en,
   input  logic                 buf_en,
   input  logic                 int_en,
   input  logic                 dir_int,
   input  logic                 ext_sck,
   input  logic                 ext_fs,
   input  logic                 sdi,
   output logic                 sck_out,
   output logic                 fs_out,
   output logic                 clk_oe,
   input  logic                 rd_en,
   output logic [WORD_BITS-1:0] rd_data,
   output logic                 rx_full,
   output logic                 rx_irq,
   output logic                 overrun
);

   import serial_rx_pkg::*;

   localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);

   generate
      if (SLOT_BITS < WORD_BITS) begin : g_bad_slot
         $error("serial_rx: SLOT_BITS must not be below WORD_BITS");
      end
   endgenerate

   rx_line_t line_raw;
   rx_line_t line_s;
   logic     sck_prev;
   logic     ext_tick;

   assign line_raw = '{sck: ext_sck, fs: ext_fs, sd: sdi};

   serial_rx_sync #(
      .WIDTH (LINE_W),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw),
      .dout (line_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= line_s.sck;
   end

   assign ext_tick = line_s.sck && !sck_prev;

   logic gen_sck;
   logic gen_fs;
   logic gen_tick;

   serial_rx_bitgen #(
      .HALF_DIV (HALF_DIV),
      .SLOT_BITS(SLOT_BITS)
   ) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (dir_int),
      .sck_o (gen_sck),
      .fs_o  (gen_fs),
      .tick_o(gen_tick)
   );

   logic bit_tick;
   logic bit_fs;

   assign bit_tick = dir_int ? gen_tick : ext_tick;
   assign bit_fs   = dir_int ? gen_fs   : line_s.fs;

   logic                 w_done;
   logic [WORD_BITS-1:0] w_word;

   serial_rx_shift #(
      .WORD_BITS(WORD_BITS)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (bit_tick),
      .fs    (bit_fs),
      .sd    (line_s.sd),
      .rx_en (rx_en),
      .done_o(w_done),
      .word_o(w_word)
   );

   logic [CNT_W-1:0] fill;
   logic [CNT_W-1:0] cap;

   serial_rx_buf #(
      .WORD_BITS(WORD_BITS),
      .DEPTH    (BUF_DEPTH)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (w_done),
      .wdata (w_word),
      .rd    (rd_en),
      .buf_en(buf_en),
      .rdata (rd_data),
      .fill_o(fill),
      .cap_o (cap),
      .full_o(rx_full),
      .ovr_o (overrun)
   );

   assign rx_irq  = rx_full && int_en;
   assign sck_out = dir_int && gen_sck;
   assign fs_out  = dir_int && gen_fs;
   assign clk_oe  = dir_int;

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned CNT_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_en,
   input logic             rd_en,
   input logic             dir_int,
   input logic             sck_out,
   input logic             fs_out,
   input logic             w_done,
   input logic [CNT_W-1:0] fill,
   input logic [CNT_W-1:0] cap,
   input logic             overrun,
   input logic             rx_full,
   input logic             rx_irq
);

   // R8
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_done && fill == cap && !rd_en) |=> overrun);

   // R3
   done_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_done |-> $past(rx_en));

   // R6
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   // R7
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && fill != '0 && !w_done) |=> (fill == $past(fill) - 1'b1));

   // R9
   irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);

   // R10
   fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_int && sck_out && $past(sck_out)) |-> $stable(fs_out));

   // R11
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_done && rd_en && fill == cap && fill != '0) |=> (fill == $past(fill) && !$rose(overrun)));

endmodule

bind serial_rx serial_rx_chk #(
   .DEPTH(BUF_DEPTH),
   .CNT_W(CNT_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rx_en  (rx_en),
   .rd_en  (rd_en),
   .dir_int(dir_int),
   .sck_out(sck_out),
   .fs_out (fs_out),
   .w_done (w_done),
   .fill   (fill),
   .cap    (cap),
   .overrun(overrun),
   .rx_full(rx_full),
   .rx_irq (rx_irq)
);

// File: tb/serial_rx_test.sv
module serial_rx_test;

   localparam int W     = 8;
   localparam int DEPTH = 2;
   localparam int HALF  = 4;
   localparam int SLOT  = 10;

   // 125 MHz: 8 time units of 1 ns per period
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         rx_en = 1'b1, buf_en = 1'b0, int_en = 1'b1, dir_int = 1'b0;
   logic         ext_sck = 1'b0, ext_fs = 1'b0, sdi = 1'b0, rd_en = 1'b0;
   logic         sck_out, fs_out, clk_oe, rx_full, rx_irq, overrun;
   logic [W-1:0] rd_data;

   serial_rx #(.WORD_BITS(W), .BUF_DEPTH(DEPTH), .SYNC_STAGES(2),
               .HALF_DIV(HALF), .SLOT_BITS(SLOT)) uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .buf_en(buf_en), .int_en(int_en),
      .dir_int(dir_int), .ext_sck(ext_sck), .ext_fs(ext_fs), .sdi(sdi),
      .sck_out(sck_out), .fs_out(fs_out), .clk_oe(clk_oe), .rd_en(rd_en),
      .rd_data(rd_data), .rx_full(rx_full), .rx_irq(rx_irq), .overrun(overrun));

   int errors = 0;
   int checks = 0;
   bit done_flag = 0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // ---------------- reference model: pin history, word assembly, store ----------------
   bit   model_on = 1;
   bit   h_sck [4];
   bit   h_fs  [4];
   bit   h_sd  [4];
   int   m_q[$];
   bit   m_ovr, m_pend, m_busy, m_ok;
   int   m_cnt, m_word, m_pword;

   function automatic int cap_now();
      return buf_en ? DEPTH : 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         m_ovr = 0; m_pend = 0; m_busy = 0; m_ok = 0; m_cnt = 0; m_word = 0; m_pword = 0;
         for (int i = 0; i < 4; i++) begin h_sck[i] = 0; h_fs[i] = 0; h_sd[i] = 0; end
      end else if (model_on) begin
         if (rd_en) begin
            if (m_q.size() > 0) void'(m_q.pop_front());
            m_ovr = 0;
         end
         if (m_pend) begin
            if (m_q.size() < cap_now()) m_q.push_back(m_pword);
            else m_ovr = 1;
         end
         m_pend = 0;
         for (int i = 3; i > 0; i--) begin
            h_sck[i] = h_sck[i-1]; h_fs[i] = h_fs[i-1]; h_sd[i] = h_sd[i-1];
         end
         h_sck[0] = ext_sck; h_fs[0] = ext_fs; h_sd[0] = sdi;
         if (h_sck[2] && !h_sck[3] && (h_fs[2] || m_busy)) begin
            int pos;
            pos = h_fs[2] ? 0 : m_cnt;
            m_word = ((m_word << 1) | int'(h_sd[2])) & ((1 << W) - 1);
            if (pos == W - 2) m_ok = rx_en;
            if (pos == W - 1) begin
               m_pend  = m_ok && rx_en;
               m_pword = m_word;
               m_busy  = 0;
            end else begin
               m_busy = 1;
            end
            m_cnt = pos + 1;
         end
      end
   end

   // compare with the model on every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && model_on) begin
         int exp_full;
         exp_full = (m_q.size() >= cap_now()) ? 1 : 0;
         check("R6 full flag", int'(rx_full), exp_full);
         check("R9 irq", int'(rx_irq), exp_full & int'(int_en));
         check("R8 overrun", int'(overrun), int'(m_ovr));
         check("R1 read data", int'(rd_data), (m_q.size() > 0) ? m_q[0] : 0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk);
      #1;
   endtask

   int pre_full;

   task automatic send_word(input logic [W-1:0] v, input int off_at, input int on_at);
      for (int i = 0; i < W; i++) begin
         if (i == off_at) rx_en = 1'b0;
         if (i == on_at)  rx_en = 1'b1;
         ext_sck = 1'b0; ext_fs = (i == 0); sdi = v[W-1-i];
         repeat (4) step();
         ext_sck = 1'b1;
         for (int j = 0; j < 4; j++) begin
            step();
            if (i == W - 1 && j == 2) pre_full = int'(rx_full);
         end
      end
      ext_sck = 1'b0; ext_fs = 1'b0; sdi = 1'b0; rx_en = 1'b1;
      repeat (2) step();
   endtask

   task automatic read_word();
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
      step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) step();
      rst_n = 1'b1;
      step();

      // reset state
      check("R1 reset data", int'(rd_data), 0);
      check("R5 reset full", int'(rx_full), 0);
      check("R8 reset overrun", int'(overrun), 0);
      check("R9 reset irq", int'(rx_irq), 0);
      check("R10 reset clk_oe", int'(clk_oe), 0);

      // single-word mode, latency and data order
      send_word(8'hA5, -1, -1);
      check("R2 not before fourth edge", pre_full, 0);
      check("R5 full after one word", int'(rx_full), 1);
      check("R1 msb first", int'(rd_data), 'hA5);
      check("R9 irq with enable", int'(rx_irq), 1);
      int_en = 1'b0; step();
      check("R9 irq masked", int'(rx_irq), 0);
      int_en = 1'b1;
      read_word();
      check("R7 full clears on read", int'(rx_full), 0);
      check("R1 empty reads zero", int'(rd_data), 0);

      // buffered mode
      buf_en = 1'b1; step();
      send_word(8'h3C, -1, -1);
      check("R6 one word not full", int'(rx_full), 0);
      check("R6 first word visible", int'(rd_data), 'h3C);
      send_word(8'hC3, -1, -1);
      check("R6 two words full", int'(rx_full), 1);
      read_word();
      check("R7 oldest popped", int'(rd_data), 'hC3);
      check("R7 below threshold", int'(rx_full), 0);
      read_word();

      // overrun
      send_word(8'h11, -1, -1);
      send_word(8'h22, -1, -1);
      send_word(8'h33, -1, -1);
      check("R8 overrun set", int'(overrun), 1);
      check("R8 stored word kept", int'(rd_data), 'h11);
      read_word();
      check("R8 read clears overrun", int'(overrun), 0);
      check("R8 dropped word absent", int'(rd_data), 'h22);
      read_word();
      check("R8 store empty", int'(rd_data), 0);

      // enable gating, single-word mode
      buf_en = 1'b0; step();
      send_word(8'h5A, 2, -1);
      check("R3 disabled mid word", int'(rx_full), 0);
      send_word(8'h6B, 2, 5);
      check("R4 re-enabled early", int'(rx_full), 1);
      check("R4 word intact", int'(rd_data), 'h6B);
      read_word();
      send_word(8'h7C, 2, 7);
      check("R3 re-enabled at last bit", int'(rx_full), 0);
      send_word(8'h4D, 7, -1);
      check("R3 disabled at last bit", int'(rx_full), 0);
      send_word(8'h2E, 0, 6);
      check("R4 enabled at second-to-last", int'(rd_data), 'h2E);
      read_word();

      // read and completion in the same cycle
      send_word(8'h81, -1, -1);
      fork
         send_word(8'h92, -1, -1);
         begin
            int guard = 0;
            do begin step(); guard++; end while (!m_pend && guard < 200);
            rd_en = 1'b1;
            step();
            rd_en = 1'b0;
         end
      join
      check("R11 new word stored", int'(rd_data), 'h92);
      check("R11 still full", int'(rx_full), 1);
      check("R11 no overrun", int'(overrun), 0);
      read_word();

      // internal clock generation
      model_on = 0;
      begin
         logic [W-1:0] v = 8'hB7;
         int idx = 0, falls = 0, t1 = 0, t2 = 0, got = -1;
         bit prev = 0;
         dir_int = 1'b1; sdi = v[W-1];
         step();
         check("R10 clk_oe", int'(clk_oe), 1);
         for (int n = 0; n < 600; n++) begin
            step();
            if (prev && !sck_out) begin
               falls++;
               if (falls == 1) t1 = n;
               if (falls == 2) t2 = n;
               idx = fs_out ? 0 : idx + 1;
               sdi = (idx < W) ? v[W-1-idx] : 1'b0;
            end
            prev = sck_out;
            if (rx_full && got < 0) got = int'(rd_data);
            if (overrun) break;
         end
         check("R10 bit clock period", t2 - t1, 2 * HALF);
         check("R10 word on internal clock", got, 'hB7);
         check("R8 overrun on next frame", int'(overrun), 1);
      end

      finish_run();
   end

endmodule